// File: doc/BRIEF.md
# Dual-Bank Register File with Split Exchange

This block is the byte-register store of a small 8-bit processor core. It keeps two complete copies of eight byte registers: an accumulator, a flag byte and six general registers, named B, C, D, E, H and L. One copy is the main bank and the other the alternate. The rest of the core sees only the active copy. It reads that copy through two independent read ports, each of which can return a single byte or a 16-bit register pair. It writes through one port that takes either a byte or a pair.

The accumulator and flags switch banks apart from the general registers. A context-switch routine uses `swap_af` to trade only the accumulator and flag byte for their alternates. It uses `swap_gp` to trade all six general registers in one step. Each strobe flips a one-bit bank pointer, so no data moves during a swap. The current pointers come out of the block on `af_bank` and `gp_bank`.

Top module: `dual_bank_regfile`

## Requirements
- R1: During and after a synchronous reset (`rst_n` low at a clock edge), `af_bank` and `gp_bank` are 0 (main bank), and every register in both banks reads 0.
- R2: A byte read (`rdN_wide`=0) decodes `rdN_sel` as 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=A, 7=F. It returns that register of the active bank in bits [7:0], with bits [15:8] at 0. Reads are combinational.
- R3: A pair read (`rdN_wide`=1) decodes `rdN_sel[1:0]` as 0=BC, 1=DE, 2=HL, with the first-named register in bits [15:8]. `rdN_sel[2]` is ignored, and code 3 returns 0.
- R4: A byte write (`wr_en`=1, `wr_wide`=0) loads `wr_data[7:0]` into the register chosen by `wr_sel`, with the R2 code. The new value is visible on both read ports after that clock edge.
- R5: A pair write (`wr_wide`=1) updates both bytes of the pair chosen by `wr_sel[1:0]` (R3 code) on one clock edge: `wr_data[15:8]` goes to the high register and `wr_data[7:0]` to the low register. Pair code 3 changes no register.
- R6: `swap_af` flips `af_bank` at the clock edge. The accumulator and flags then read from the other bank, and the general registers and their bank stay as they were.
- R7: `swap_gp` flips `gp_bank` at the clock edge. All six general registers then read from the other bank, and A, F and `af_bank` stay as they were.
- R8: A register in the hidden bank keeps its value through any number of writes to the active bank. It reappears unchanged when its bank becomes active again.
- R9: A write in the same cycle as a swap lands in the bank that was active before that edge.
- R10: `swap_af` and `swap_gp` asserted together flip both pointers, each independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_wide | input | 1 | Read port 0: 1 = pair, 0 = byte |
| rd0_sel | input | 3 | Read port 0 register or pair code |
| rd0_data | output | 16 | Read port 0 data |
| rd1_wide | input | 1 | Read port 1: 1 = pair, 0 = byte |
| rd1_sel | input | 3 | Read port 1 register or pair code |
| rd1_data | output | 16 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | Write size: 1 = pair, 0 = byte |
| wr_sel | input | 3 | Write register or pair code |
| wr_data | input | 16 | Write data; a byte write uses bits [7:0] |
| swap_af | input | 1 | Exchange accumulator and flags with alternates |
| swap_gp | input | 1 | Exchange all six general registers with alternates |
| af_bank | output | 1 | Bank currently holding visible A/F (0 = main) |
| gp_bank | output | 1 | Bank currently holding visible B..L (0 = main) |

## Verification
A wrong bank pointer shows on the very next read of any register whose bank contents differ, so the bench fills the two banks with distinct values before every swap. A misrouted write or a write into the hidden bank stays out of sight until that bank becomes visible again. The bench therefore swaps back and sweeps every byte and pair code on both ports under all four pointer combinations. A dropped pair byte or a swapped byte order shows on the first pair read after the write.

// File: rtl/dbrf_pkg.sv
// Shared constants for the dual-bank register file.
// Register code: 0..5 = B,C,D,E,H,L (general), 6 = A, 7 = F.
package dbrf_pkg;
    localparam int NUM_GP   = 6;
    localparam int NUM_AF   = 2;
    localparam int NUM_REGS = NUM_GP + NUM_AF;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam logic [1:0] PAIR_NONE = 2'd3;
endpackage

// File: rtl/dbrf_bank_toggle.sv
// One-bit bank pointer. Assumes flip is a single-cycle strobe;
// each strobe moves the pointer to the other bank. Reset selects main.
module dbrf_bank_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic sel
);
    // Pointer register: clears on reset, inverts on a flip strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel <= 1'b0;
        else if (flip) sel <= ~sel;
    end

    // R6 / R7: a strobe always changes the pointer
    p_flip_changes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> sel != $past(sel));
    // R6 / R7: without a strobe the pointer holds
    p_hold_without_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flip |=> $stable(sel));
endmodule

// File: rtl/dbrf_bank_pair.sv
// Two copies of N registers of width W. Only the copy chosen by
// bank_sel is visible and writable; the other copy holds its contents.
// Assumes we/wd are already decoded per register.
module dbrf_bank_pair #(
    parameter int N = 6,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bank_sel,
    input  logic [N-1:0]        we,
    input  logic [N-1:0][W-1:0] wd,
    output logic [N-1:0][W-1:0] view
);
    logic [N-1:0][W-1:0] mem0;
    logic [N-1:0][W-1:0] mem1;

    // Storage: clear both copies on reset, write only the active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem0 <= '0;
            mem1 <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (we[i]) begin
                    if (bank_sel) mem1[i] <= wd[i];
                    else          mem0[i] <= wd[i];
                end
            end
        end
    end

    // Visible copy, one selector per register.
    for (genvar g = 0; g < N; g++) begin : g_view
        assign view[g] = bank_sel ? mem1[g] : mem0[g];
    end

    // R8: the hidden copy never changes
    p_hidden_main_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel |=> $stable(mem0));
    p_hidden_alt_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_sel |=> $stable(mem1));
endmodule

// File: rtl/dbrf_read_port.sv
// Combinational read port over the active register view.
// Byte mode returns one register zero-extended; pair mode returns
// {even register, odd register} for pair codes 0..2 and zero for code 3.
module dbrf_read_port
    import dbrf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                       wide,
    input  logic [SEL_W-1:0]           sel,
    input  logic [NUM_REGS-1:0][W-1:0] regs,
    output logic [2*W-1:0]             data
);
    logic [SEL_W-1:0] hi_idx;
    logic [SEL_W-1:0] lo_idx;

    assign hi_idx = {sel[1:0], 1'b0};
    assign lo_idx = {sel[1:0], 1'b1};

    // Output selection for byte and pair reads.
    always_comb begin
        data = '0;
        if (!wide)                      data[W-1:0] = regs[sel];
        else if (sel[1:0] != PAIR_NONE) data = {regs[hi_idx], regs[lo_idx]};
    end
endmodule

// File: rtl/dual_bank_regfile.sv
// Dual-bank byte register file with separate exchange of A/F and of the
// six general registers. Two combinational read ports, one write port.
// Assumes swap strobes and write controls are synchronous to clk.
module dual_bank_regfile
    import dbrf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd0_wide,
    input  logic [2:0]       rd0_sel,
    output logic [2*W-1:0]   rd0_data,
    input  logic             rd1_wide,
    input  logic [2:0]       rd1_sel,
    output logic [2*W-1:0]   rd1_data,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [2:0]       wr_sel,
    input  logic [2*W-1:0]   wr_data,
    input  logic             swap_af,
    input  logic             swap_gp,
    output logic             af_bank,
    output logic             gp_bank
);
    logic [NUM_REGS-1:0]        we8;
    logic [NUM_REGS-1:0][W-1:0] wd8;
    logic [NUM_REGS-1:0][W-1:0] view8;
    logic [NUM_GP-1:0][W-1:0]   gp_view;
    logic [NUM_AF-1:0][W-1:0]   af_view;
    logic [SEL_W-1:0]           wr_hi;
    logic [SEL_W-1:0]           wr_lo;

    assign wr_hi = {wr_sel[1:0], 1'b0};
    assign wr_lo = {wr_sel[1:0], 1'b1};

    // Write decode: per-register enable and data for byte and pair writes.
    always_comb begin
        we8 = '0;
        for (int i = 0; i < NUM_REGS; i++) wd8[i] = wr_data[W-1:0];
        if (wr_en) begin
            if (!wr_wide) begin
                we8[wr_sel] = 1'b1;
            end else if (wr_sel[1:0] != PAIR_NONE) begin
                we8[wr_hi] = 1'b1;
                we8[wr_lo] = 1'b1;
                wd8[wr_hi] = wr_data[2*W-1:W];
            end
        end
    end

    dbrf_bank_toggle i_af_toggle (
        .clk (clk), .rst_n (rst_n), .flip (swap_af), .sel (af_bank)
    );
    dbrf_bank_toggle i_gp_toggle (
        .clk (clk), .rst_n (rst_n), .flip (swap_gp), .sel (gp_bank)
    );

    dbrf_bank_pair #(.N(NUM_GP), .W(W)) i_gp_banks (
        .clk (clk), .rst_n (rst_n), .bank_sel (gp_bank),
        .we (we8[NUM_GP-1:0]), .wd (wd8[NUM_GP-1:0]), .view (gp_view)
    );
    dbrf_bank_pair #(.N(NUM_AF), .W(W)) i_af_banks (
        .clk (clk), .rst_n (rst_n), .bank_sel (af_bank),
        .we (we8[NUM_REGS-1:NUM_GP]), .wd (wd8[NUM_REGS-1:NUM_GP]), .view (af_view)
    );

    assign view8 = {af_view, gp_view};

    dbrf_read_port #(.W(W)) i_rd0 (
        .wide (rd0_wide), .sel (rd0_sel), .regs (view8), .data (rd0_data)
    );
    dbrf_read_port #(.W(W)) i_rd1 (
        .wide (rd1_wide), .sel (rd1_sel), .regs (view8), .data (rd1_data)
    );

    // R1: reset returns both pointers to the main bank
    p_reset_main_r1: assert property (@(posedge clk)
        !rst_n |=> (!af_bank && !gp_bank));
    // R4: a byte write without a swap is visible next cycle
    p_byte_write_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide && !swap_af && !swap_gp) |=>
            view8[$past(wr_sel)] == $past(wr_data[W-1:0]));
    // R5: a pair write updates both bytes on one edge
    p_pair_write_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide && wr_sel[1:0] != PAIR_NONE && !swap_gp) |=>
            (view8[$past(wr_hi)] == $past(wr_data[2*W-1:W]) &&
             view8[$past(wr_lo)] == $past(wr_data[W-1:0])));
    // R6: an A/F swap alone leaves the general registers untouched
    p_af_swap_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_af && !swap_gp && !wr_en) |=> ($stable(gp_view) && $stable(gp_bank)));
endmodule

// File: tb/test_dual_bank_regfile.sv
`timescale 1ns/1ps
module test_dual_bank_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd0_wide = 1'b0, rd1_wide = 1'b0;
    logic [2:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
    logic [15:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 1'b0, wr_wide = 1'b0, swap_af = 1'b0, swap_gp = 1'b0;
    logic        af_bank, gp_bank;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [2][8];
    logic       m_af = 1'b0, m_gp = 1'b0;

    always #4 clk = ~clk;

    dual_bank_regfile i_dual_bank_regfile (
        .clk (clk), .rst_n (rst_n),
        .rd0_wide (rd0_wide), .rd0_sel (rd0_sel), .rd0_data (rd0_data),
        .rd1_wide (rd1_wide), .rd1_sel (rd1_sel), .rd1_data (rd1_data),
        .wr_en (wr_en), .wr_wide (wr_wide), .wr_sel (wr_sel), .wr_data (wr_data),
        .swap_af (swap_af), .swap_gp (swap_gp), .af_bank (af_bank), .gp_bank (gp_bank)
    );

    function automatic logic [15:0] expect_rd(input logic wide, input logic [2:0] sel);
        int p;
        if (!wide) return {8'h00, mdl[(sel >= 6) ? m_af : m_gp][sel]};
        p = int'(sel[1:0]);
        if (p == 3) return 16'h0000;
        return {mdl[m_gp][2*p], mdl[m_gp][2*p+1]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Sweep every byte and pair code on both ports; port 1 runs in reverse order.
    task automatic check_all(input string tag);
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 8; s++) begin
                rd0_wide = w[0]; rd0_sel = s[2:0];
                rd1_wide = w[0]; rd1_sel = 3'(7 - s);
                #1;
                check(tag, rd0_data, expect_rd(w[0], s[2:0]));
                check(tag, rd1_data, expect_rd(w[0], 3'(7 - s)));
            end
        end
        check({tag, " af_bank"}, {15'd0, af_bank}, {15'd0, m_af});
        check({tag, " gp_bank"}, {15'd0, gp_bank}, {15'd0, m_gp});
    endtask

    // One cycle of stimulus, driven at the falling edge; the model writes into the pre-swap bank.
    task automatic step(input logic we, input logic wide, input logic [2:0] sel,
                        input logic [15:0] d, input logic saf, input logic sgp);
        @(negedge clk);
        wr_en = we; wr_wide = wide; wr_sel = sel; wr_data = d; swap_af = saf; swap_gp = sgp;
        @(posedge clk);
        if (we) begin
            if (!wide) mdl[(sel >= 6) ? m_af : m_gp][sel] = d[7:0];
            else if (sel[1:0] != 2'd3) begin
                mdl[m_gp][{sel[1:0], 1'b0}] = d[15:8];
                mdl[m_gp][{sel[1:0], 1'b1}] = d[7:0];
            end
        end
        if (saf) m_af = ~m_af;
        if (sgp) m_gp = ~m_gp;
        @(negedge clk);
        wr_en = 1'b0; swap_af = 1'b0; swap_gp = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int r = 0; r < 8; r++) mdl[b][r] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check_all("R1 reset");

        // R2/R4: byte writes into the main bank, distinct per register
        for (int r = 0; r < 8; r++) step(1'b1, 1'b0, 3'(r), 16'(8'h31 + 8'(r * 17)), 1'b0, 1'b0);
        check_all("R2 R4 byte");
        // R3/R5: pair writes, code 3 must change nothing; sel[2] ignored for pairs
        step(1'b1, 1'b1, 3'd0, 16'h1234, 1'b0, 1'b0);
        step(1'b1, 1'b1, 3'd5, 16'h5678, 1'b0, 1'b0);
        step(1'b1, 1'b1, 3'd2, 16'h9ABC, 1'b0, 1'b0);
        step(1'b1, 1'b1, 3'd3, 16'hDEAD, 1'b0, 1'b0);
        step(1'b1, 1'b1, 3'd7, 16'hBEEF, 1'b0, 1'b0);
        check_all("R3 R5 pair");
        // R6: A/F swap only, then fill alternate A/F
        step(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b0);
        check_all("R6 af swap");
        step(1'b1, 1'b0, 3'd6, 16'h00C6, 1'b0, 1'b0);
        step(1'b1, 1'b0, 3'd7, 16'h00F7, 1'b0, 1'b0);
        check_all("R6 af alt");
        // R7: general swap, fill alternate generals
        step(1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
        check_all("R7 gp swap");
        for (int r = 0; r < 6; r++) step(1'b1, 1'b0, 3'(r), 16'(8'hE0 + 8'(r)), 1'b0, 1'b0);
        step(1'b1, 1'b1, 3'd1, 16'h4D45, 1'b0, 1'b0);
        check_all("R7 gp alt");
        // R10: both swaps together; R8: main contents reappear unchanged
        step(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
        check_all("R10 R8 both back");
        // R9: write in the swap cycle lands in the old bank
        step(1'b1, 1'b0, 3'd6, 16'h00AA, 1'b1, 1'b0);
        check_all("R9 af write+swap");
        step(1'b1, 1'b1, 3'd2, 16'h7711, 1'b0, 1'b1);
        check_all("R9 gp write+swap");
        step(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
        check_all("R9 R8 return");
        step(1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
        check_all("R8 mixed banks");
        // R1: reset again clears both banks and pointers
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        for (int b = 0; b < 2; b++) for (int r = 0; r < 8; r++) mdl[b][r] = 8'h00;
        m_af = 1'b0; m_gp = 1'b0;
        check_all("R1 re-reset");
        step(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
        check_all("R1 alt cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule